// File: doc/BRIEF.md
# Three-Ratio Prescaler Divider Controller

This block is the programmable counter of a main synthesizer divider that sits behind an external prescaler with three ratios: 64, 65 and 72. It runs on the prescaler output clock and counts one step per prescaler output cycle. For each such cycle it drives a two-bit ratio select that tells the prescaler how many input cycles the next output cycle takes. Three programmed counts set how many cycles of each ratio make up one comparison period.

A period starts with the 72 phase, continues with the 65 phase and closes with the 64 phase. The 72 phase lasts `cnt72 + 1` cycles, the 65 phase lasts `cnt65` cycles and the 64 phase lasts `cnt64 + 2` cycles. A phase with a count of zero is skipped without any dead cycle. A carry from an external fractional accumulator adds one input cycle to the period by turning the first 64 cycle into a 65 cycle. The division ratio seen at the prescaler input is therefore N = 64·(cnt64+2) + 65·cnt65 + 72·(cnt72+1) + carry. The block marks the last cycle of each period with a one-cycle pulse for the phase detector. The counts and the carry are captured only at period boundaries, so a reprogram never produces a mixed period.

Top module: `tri_mod_divider`

## Requirements
- R1: The select encodes the prescaler ratio as 2'b00 = divide by 64, 2'b01 = divide by 65 and 2'b10 = divide by 72; the value 2'b11 never appears.
- R2: Every period opens with exactly `cnt72 + 1` consecutive cycles with the select at 2'b10.
- R3: Exactly `cnt65` cycles with the select at 2'b01 follow the 72 phase. When `cnt65` is 0, the 64 phase starts on the cycle right after the last 72 cycle.
- R4: The period closes with `cnt64 + 2` cycles of the 64 phase, all with the select at 2'b00 except the one named in R5.
- R5: When the carry captured for a period is 1, the first cycle of its 64 phase drives 2'b01 instead of 2'b00. When the carry is 0, the 64 phase is all 2'b00.
- R6: `div_pulse` is high during the last cycle of each period only, for one cycle, and the select is 2'b00 during that cycle.
- R7: The prescaler input cycles per period, summed over the selected ratios, equal 64·(cnt64+2) + 65·cnt65 + 72·(cnt72+1) + carry.
- R8: The counts and the carry are sampled at the clock edge that ends a period (the edge closing the `div_pulse` cycle). A change during a period leaves that period unchanged and governs the next one.
- R9: Reset is synchronous and active high. The first cycle after reset is the first cycle of a period in the 72 phase, using the counts and carry present at the reset edge, with `div_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock; one edge per prescaler cycle |
| rst | input | 1 | Synchronous active-high reset |
| cnt64 | input | 12 | Count for the 64 phase; the phase runs cnt64+2 cycles |
| cnt65 | input | 12 | Count for the 65 phase; the phase runs cnt65 cycles |
| cnt72 | input | 8 | Count for the 72 phase; the phase runs cnt72+1 cycles |
| frac_carry | input | 1 | Fractional +1 request for the next period |
| mod_sel | output | 2 | Prescaler ratio select for the current cycle |
| div_pulse | output | 1 | One-cycle pulse on the last cycle of each period |

## Verification
A corrupted phase or remaining count shows up at once as a wrong select value in the cycle where the phase boundary should fall. It also moves the divided pulse, so the period length and the summed prescaler ratio drift within the same period. A bad snapshot of the counts or the carry shows up as a wrong phase length or a missing 65 slot in the period that follows the boundary. The bench therefore checks the select cycle by cycle over whole periods and also compares the ratio sum per period with the formula. This catches both kinds of fault within one period.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    // Widest count supported by the internal datapath
    localparam int CNT_W = 12;
    // Remaining-cycle counter must hold cnt64 + 1
    localparam int REM_W = CNT_W + 1;

    localparam logic [1:0] SEL_64 = 2'b00;
    localparam logic [1:0] SEL_65 = 2'b01;
    localparam logic [1:0] SEL_72 = 2'b10;

    typedef enum logic [1:0] {
        PH_72 = 2'd0,
        PH_65 = 2'd1,
        PH_64 = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] n64;
        logic [CNT_W-1:0] n65;
        logic [CNT_W-1:0] n72;
        logic             carry;
    } cfg_t;

    typedef struct packed {
        phase_e           phase;
        logic [REM_W-1:0] rem;
    } seq_t;

    // Length of the 64 phase minus one
    function automatic logic [REM_W-1:0] last64(input logic [CNT_W-1:0] n);
        return {1'b0, n} + REM_W'(1);
    endfunction

endpackage

// File: rtl/tpd_cfg_latch.sv
module tpd_cfg_latch
    import tpd_pkg::*;
#(
    parameter int A_W = 12,
    parameter int B_W = 12,
    parameter int C_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [A_W-1:0] n64_in,
    input  logic [B_W-1:0] n65_in,
    input  logic [C_W-1:0] n72_in,
    input  logic           carry_in,
    output cfg_t           cfg_q,
    output cfg_t           cfg_d
);

    cfg_t cfg_port;

    always_comb begin
        cfg_port.n64   = CNT_W'(n64_in);
        cfg_port.n65   = CNT_W'(n65_in);
        cfg_port.n72   = CNT_W'(n72_in);
        cfg_port.carry = carry_in;
    end

    // Value in force for the cycle after the coming edge
    assign cfg_d = (rst || load) ? cfg_port : cfg_q;

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

endmodule

// File: rtl/tpd_phase_seq.sv
module tpd_phase_seq
    import tpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_q,
    input  cfg_t cfg_d,
    output seq_t seq_q,
    output logic period_end
);

    seq_t seq_n;
    logic phase_done;

    assign phase_done = (seq_q.rem == '0);
    assign period_end = phase_done && (seq_q.phase == PH_64);

    always_comb begin
        seq_n = seq_q;
        if (!phase_done) begin
            seq_n.rem = seq_q.rem - REM_W'(1);
        end else begin
            unique case (seq_q.phase)
                PH_72: begin
                    if (cfg_q.n65 != '0) begin
                        seq_n.phase = PH_65;
                        seq_n.rem   = {1'b0, cfg_q.n65} - REM_W'(1);
                    end else begin
                        seq_n.phase = PH_64;
                        seq_n.rem   = last64(cfg_q.n64);
                    end
                end
                PH_65: begin
                    seq_n.phase = PH_64;
                    seq_n.rem   = last64(cfg_q.n64);
                end
                default: begin
                    seq_n.phase = PH_72;
                    seq_n.rem   = {1'b0, cfg_d.n72};
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.phase <= PH_72;
            seq_q.rem   <= {1'b0, cfg_d.n72};
        end else begin
            seq_q <= seq_n;
        end
    end

endmodule

// File: rtl/tpd_sel_decode.sv
module tpd_sel_decode
    import tpd_pkg::*;
(
    input  seq_t       seq_q,
    input  cfg_t       cfg_q,
    output logic [1:0] sel,
    output logic       pulse
);

    logic first64;

    assign first64 = (seq_q.rem == last64(cfg_q.n64));

    always_comb begin
        unique case (seq_q.phase)
            PH_72:   sel = SEL_72;
            PH_65:   sel = SEL_65;
            default: sel = (cfg_q.carry && first64) ? SEL_65 : SEL_64;
        endcase
    end

    assign pulse = (seq_q.phase == PH_64) && (seq_q.rem == '0);

endmodule

// File: rtl/tri_mod_divider.sv
module tri_mod_divider
    import tpd_pkg::*;
#(
    parameter int A_W = 12,
    parameter int B_W = 12,
    parameter int C_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] cnt64,
    input  logic [B_W-1:0] cnt65,
    input  logic [C_W-1:0] cnt72,
    input  logic           frac_carry,
    output logic [1:0]     mod_sel,
    output logic           div_pulse
);

    cfg_t cfg_q;
    cfg_t cfg_d;
    seq_t seq_q;
    logic period_end;

    tpd_cfg_latch #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (period_end),
        .n64_in   (cnt64),
        .n65_in   (cnt65),
        .n72_in   (cnt72),
        .carry_in (frac_carry),
        .cfg_q    (cfg_q),
        .cfg_d    (cfg_d)
    );

    tpd_phase_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_q      (cfg_q),
        .cfg_d      (cfg_d),
        .seq_q      (seq_q),
        .period_end (period_end)
    );

    tpd_sel_decode u_dec (
        .seq_q (seq_q),
        .cfg_q (cfg_q),
        .sel   (mod_sel),
        .pulse (div_pulse)
    );

endmodule

// File: rtl/tri_mod_divider_chk.sv
module tri_mod_divider_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mod_sel,
    input logic       div_pulse
);

    // R1: illegal select code never driven
    a_r1_legal_sel: assert property (@(posedge clk) disable iff (rst)
        mod_sel != 2'b11);

    // R6: pulse lasts a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R6: the closing cycle is a 64 cycle
    a_r6_pulse_in_64: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> mod_sel == 2'b00);

    // R2: a new period opens in the 72 phase
    a_r2_open_72: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> mod_sel == 2'b10);

    // R3: the 72 phase cannot follow a 65 cycle inside a period
    a_r3_no_back_to_72: assert property (@(posedge clk) disable iff (rst)
        (mod_sel == 2'b01) |=> mod_sel != 2'b10);

    // R4: a 64 cycle is never followed by a 65 or 72 cycle without a pulse
    a_r4_64_stays: assert property (@(posedge clk) disable iff (rst)
        (mod_sel == 2'b00 && !div_pulse) |=> mod_sel == 2'b00);

endmodule

bind tri_mod_divider tri_mod_divider_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mod_sel   (mod_sel),
    .div_pulse (div_pulse)
);

// File: tb/tri_mod_divider_tb.sv
module tri_mod_divider_tb;

    localparam int CLK_NS = 10;
    localparam int WDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cnt64 = '0;
    logic [11:0] cnt65 = '0;
    logic [7:0]  cnt72 = '0;
    logic        frac_carry = 1'b0;
    logic [1:0]  mod_sel;
    logic        div_pulse;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_NS/2) clk = ~clk;

    tri_mod_divider u_dut (
        .clk        (clk),
        .rst        (rst),
        .cnt64      (cnt64),
        .cnt65      (cnt65),
        .cnt72      (cnt72),
        .frac_carry (frac_carry),
        .mod_sel    (mod_sel),
        .div_pulse  (div_pulse)
    );

    function automatic logic [1:0] exp_sel(int a, int b, int c, int cr, int i);
        if (i < c + 1)           return 2'b10;
        if (i < c + 1 + b)       return 2'b01;
        if (i == c + 1 + b && cr != 0) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string req_of(int b, int c, int cr, int i);
        if (i < c + 1)           return "R2";
        if (i < c + 1 + b)       return "R3";
        if (i == c + 1 + b && cr != 0) return "R5";
        return "R4";
    endfunction

    function automatic int ratio(logic [1:0] s);
        case (s)
            2'b00:   return 64;
            2'b01:   return 65;
            2'b10:   return 72;
            default: return 0;
        endcase
    endfunction

    task automatic apply(int a, int b, int c, int cr);
        cnt64      = 12'(a);
        cnt65      = 12'(b);
        cnt72      = 8'(c);
        frac_carry = (cr != 0);
    endtask

    // Checks cycles [i0, L) of a period. mode 0: current cycle is i0;
    // mode 1: wait for a pulse first; mode 2: next negedge is i0.
    task automatic check_span(int a, int b, int c, int cr, int mode, int i0,
                              int sum_in, string tag);
        int len = c + 1 + b + a + 2;
        int sum = sum_in;
        int exp_n = 64*(a+2) + 65*b + 72*(c+1) + cr;
        bit bad = 0;
        if (mode == 1) begin
            do begin @(negedge clk); #1; end while (!div_pulse);
            @(negedge clk);
        end else if (mode == 2) begin
            @(negedge clk);
        end
        for (int i = i0; i < len; i++) begin
            if (i != i0) @(negedge clk);
            #1;
            sum += ratio(mod_sel);
            if (!bad && mod_sel != exp_sel(a, b, c, cr, i)) begin
                bad = 1;
                $display("FAIL %s %s cycle %0d: mod_sel=%b expected %b",
                         req_of(b, c, cr, i), tag, i, mod_sel, exp_sel(a, b, c, cr, i));
            end
            if (!bad && div_pulse != (i == len - 1)) begin
                bad = 1;
                $display("FAIL R6 %s cycle %0d: div_pulse=%b expected %b",
                         tag, i, div_pulse, (i == len - 1));
            end
        end
        n_tests++;
        if (bad) n_fail++;
        n_tests++;
        if (sum != exp_n) begin
            n_fail++;
            $display("FAIL R7 %s: ratio sum=%0d expected %0d", tag, sum, exp_n);
        end
    endtask

    task automatic t_reset;
        apply(3, 2, 1, 0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        n_tests++;
        if (mod_sel != 2'b10 || div_pulse != 1'b0) begin
            n_fail++;
            $display("FAIL R9 reset: mod_sel=%b div_pulse=%b expected 10 0",
                     mod_sel, div_pulse);
        end
        check_span(3, 2, 1, 0, 0, 0, 0, "first period after reset");
    endtask

    task automatic t_period(int a, int b, int c, int cr, string tag);
        apply(a, b, c, cr);
        check_span(a, b, c, cr, 1, 0, 0, tag);
    endtask

    // R8: a change in the middle of a period is deferred to the next one
    task automatic t_mid_change;
        int sum = 0;
        apply(4, 3, 2, 0);
        check_span(4, 3, 2, 0, 1, 0, 0, "R8 settle");
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            #1;
            sum += ratio(mod_sel);
        end
        apply(1, 0, 5, 1);
        check_span(4, 3, 2, 0, 2, 2, sum, "R8 old values hold");
        check_span(1, 0, 5, 1, 2, 0, 0, "R8 new values apply");
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_period(52, 0, 4, 1, "R5 example setting with carry");
        t_period(52, 0, 4, 0, "R3 skipped 65 phase");
        t_period(0, 0, 0, 0, "R4 shortest period");
        t_period(0, 0, 0, 1, "R5 carry on shortest period");
        t_period(10, 20, 3, 1, "R3 long 65 phase");
        t_period(300, 7, 255, 0, "R2 full 72 count");
        t_mid_change();
        t_period(5, 1, 0, 1, "R1 all three codes");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule